// File: doc/BRIEF.md
# Counter-array timebase

This block is the common 16-bit timebase shared by the compare/capture channels of a counter array in a small microcontroller. It counts up on single-cycle enables taken from one of four sources: the system clock divided by twelve, the system clock divided by four, an overflow pulse from a neighbouring timer, or a slow external clock pin that is first brought into the clock domain. Software starts and stops it with a run bit. It can also be told to stop while the core is idle.

Two byte-wide registers hold the controls. The mode register holds the idle gating, a watchdog enable that is passed on to a neighbouring block, the source select and the overflow interrupt enable. The control register holds the overflow flag, the run bit and five event flags that the compare/capture channels raise through strobes. The counter itself can be read and written as two bytes. A single interrupt line combines the enabled overflow flag with the channel event flags.

Top module: `pca_timebase`

## Requirements
- R1: After reset every register reads 0x00, `count_o` is 0, `irq_o` is 0 and `wdog_en_o` is 0. Address map: 0 = mode, 1 = control, 2 = count low byte, 3 = count high byte.
- R2: With mode bits 2:1 = 00, the counter advances once every 12 clocks, driven by a free-running prescaler.
- R3: With mode bits 2:1 = 01, the counter advances once every 4 clocks, driven by the same prescaler.
- R4: With mode bits 2:1 = 10, the counter advances once for each clock cycle in which `t0_ovf_i` is high.
- R5: With mode bits 2:1 = 11, the counter advances once for each rising edge of `ext_clk_i`. The pin passes through two synchronising flops, and the count changes on the third clock edge after the new level is first sampled. Edge rates up to one eighth of the clock are counted exactly.
- R6: The counter advances only while control bit 6 (run) is 1. Otherwise it holds its value.
- R7: When mode bit 7 is 1, the counter holds while `idle_i` is high. When mode bit 7 is 0, `idle_i` has no effect.
- R8: Control bit 7 (overflow flag) is set when the counter wraps from 0xFFFF to 0. A control write with bit 7 = 1 also sets it, and a control write with bit 7 = 0 clears it. If a wrap and a clearing write happen in the same cycle, the flag ends up set.
- R9: Control bits 4:0 follow `mod_evt_i[4:0]`: a high strobe sets the matching bit. A control write stores bits 4:0, so writing 0 clears a bit. A strobe in the same cycle as a clearing write leaves the bit set.
- R10: `irq_o` is high when the overflow flag and mode bit 0 are both 1, or when any of control bits 4:0 is 1.
- R11: Mode bits 5:3 and control bit 5 read as 0 and ignore writes. A write to a count byte replaces that byte, leaves the other byte as it is, and overrides any increment in that cycle.
- R12: `wdog_en_o` reflects mode bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_i | input | 1 | Core is in idle |
| t0_ovf_i | input | 1 | Single-cycle overflow pulse from the neighbouring timer |
| ext_clk_i | input | 1 | Asynchronous external count pin |
| mod_evt_i | input | 5 | Per-channel match/capture strobes |
| sfr_wr_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 2 | Register address |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Read data for the addressed register |
| count_o | output | 16 | Current counter value |
| irq_o | output | 1 | Combined interrupt request |
| wdog_en_o | output | 1 | Watchdog enable bit passed on |

## Verification
A wrong prescaler phase, source mux or gating term shows up on `count_o` within one prescaler period, at most twelve clocks, because the bench reference model predicts every single increment. A flag that is set or cleared when it should not be appears on `irq_o` and on the control readback in the next cycle. The same-cycle collisions between hardware sets and software clears, and between byte writes and increments, are each driven on purpose, so a wrong priority shows up at once. For the external pin, an error in the synchroniser depth moves every increment by a whole cycle, and the per-cycle comparison catches that.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int CNT_W   = 16;
  localparam int NUM_MOD = 5;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] A_CLO  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CHI  = 2'd3;

  // mode register bit positions
  localparam int M_IDLE = 7;
  localparam int M_WDOG = 6;
  localparam int M_SRC  = 1;
  localparam int M_IEN  = 0;
  // control register bit positions
  localparam int C_OVF  = 7;
  localparam int C_RUN  = 6;

  typedef enum logic [1:0] {
    SRC_DIV12 = 2'b00,
    SRC_DIV4  = 2'b01,
    SRC_T0    = 2'b10,
    SRC_EXT   = 2'b11
  } src_e;
endpackage

// File: rtl/pca_prescale.sv
module pca_prescale #(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic slow_o,
  output logic fast_o
);
  localparam int SW = $clog2(DIV_SLOW);
  localparam int FW = (DIV_FAST > 2) ? $clog2(DIV_FAST) : 1;

  logic [SW-1:0] slow_q, slow_d;
  logic [FW-1:0] fast_q, fast_d;

  assign slow_o = (slow_q == SW'(DIV_SLOW - 1));
  assign fast_o = (fast_q == FW'(DIV_FAST - 1));

  always_comb begin
    slow_d = slow_o ? '0 : slow_q + 1'b1;
    fast_d = fast_o ? '0 : fast_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= '0;
      fast_q <= '0;
    end else begin
      slow_q <= slow_d;
      fast_q <= fast_d;
    end
  end

  generate
    if (DIV_SLOW % DIV_FAST == 0) begin : g_align
      // both pulses share a phase, so every slow pulse is also a fast pulse
      assert_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slow_o |-> fast_o);
    end
  endgenerate
  assert_slow_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slow_o |=> !slow_o);
endmodule

// File: rtl/pca_edge_sync.sv
module pca_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-1:0], pin_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pca_count.sv
module pca_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         wr_lo_i,
  input  logic         wr_hi_i,
  input  logic [7:0]   wdata_i,
  output logic [W-1:0] count_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         any_wr;

  assign any_wr  = wr_lo_i | wr_hi_i;
  assign wrap_o  = en_i & ~any_wr & (&cnt_q);
  assign count_o = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo_i)     cnt_d[7:0]   = wdata_i;
    else if (wr_hi_i) cnt_d[W-1:8] = wdata_i[W-9:0];
    else if (en_i)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !any_wr) |=> count_o == $past(count_o) + 1'b1);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !any_wr) |=> $stable(count_o));
endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
  import pca_pkg::*;
#(
  parameter int PRE_SLOW  = 12,
  parameter int PRE_FAST  = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idle_i,
  input  logic               t0_ovf_i,
  input  logic               ext_clk_i,
  input  logic [NUM_MOD-1:0] mod_evt_i,
  input  logic               sfr_wr_i,
  input  logic [ADDR_W-1:0]  sfr_addr_i,
  input  logic [7:0]         sfr_wdata_i,
  output logic [7:0]         sfr_rdata_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               irq_o,
  output logic               wdog_en_o
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sn     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sn     <= rst_meta_q;
    end
  end

  // count pulse sources
  logic tick_slow, tick_fast, ext_rise;

  pca_prescale #(.DIV_SLOW(PRE_SLOW), .DIV_FAST(PRE_FAST)) u_pre (
    .clk(clk), .rst_n(rst_sn), .slow_o(tick_slow), .fast_o(tick_fast));

  pca_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_sn), .pin_i(ext_clk_i), .rise_o(ext_rise));

  // register state
  logic               idle_gate_q, idle_gate_d;
  logic               wdog_q, wdog_d;
  src_e               src_q, src_d;
  logic               ien_q, ien_d;
  logic               ovf_q, ovf_d;
  logic               run_q, run_d;
  logic [NUM_MOD-1:0] evt_q, evt_d;

  logic wr_mode, wr_ctrl, wr_lo, wr_hi;
  assign wr_mode = sfr_wr_i && (sfr_addr_i == A_MODE);
  assign wr_ctrl = sfr_wr_i && (sfr_addr_i == A_CTRL);
  assign wr_lo   = sfr_wr_i && (sfr_addr_i == A_CLO);
  assign wr_hi   = sfr_wr_i && (sfr_addr_i == A_CHI);

  logic src_tick, cnt_en, wrap;

  always_comb begin
    unique case (src_q)
      SRC_DIV12: src_tick = tick_slow;
      SRC_DIV4:  src_tick = tick_fast;
      SRC_T0:    src_tick = t0_ovf_i;
      default:   src_tick = ext_rise;
    endcase
  end

  assign cnt_en = run_q & ~(idle_i & idle_gate_q) & src_tick;

  pca_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sn), .en_i(cnt_en), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wdata_i(sfr_wdata_i), .count_o(count_o), .wrap_o(wrap));

  // next state: software write first, hardware set on top
  always_comb begin
    idle_gate_d = idle_gate_q;
    wdog_d      = wdog_q;
    src_d       = src_q;
    ien_d       = ien_q;
    ovf_d       = ovf_q;
    run_d       = run_q;
    evt_d       = evt_q;
    if (wr_mode) begin
      idle_gate_d = sfr_wdata_i[M_IDLE];
      wdog_d      = sfr_wdata_i[M_WDOG];
      src_d       = src_e'(sfr_wdata_i[M_SRC+1:M_SRC]);
      ien_d       = sfr_wdata_i[M_IEN];
    end
    if (wr_ctrl) begin
      ovf_d = sfr_wdata_i[C_OVF];
      run_d = sfr_wdata_i[C_RUN];
      evt_d = sfr_wdata_i[NUM_MOD-1:0];
    end
    ovf_d = ovf_d | wrap;
    evt_d = evt_d | mod_evt_i;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      idle_gate_q <= 1'b0;
      wdog_q      <= 1'b0;
      src_q       <= SRC_DIV12;
      ien_q       <= 1'b0;
      ovf_q       <= 1'b0;
      run_q       <= 1'b0;
      evt_q       <= '0;
    end else begin
      idle_gate_q <= idle_gate_d;
      wdog_q      <= wdog_d;
      src_q       <= src_d;
      ien_q       <= ien_d;
      ovf_q       <= ovf_d;
      run_q       <= run_d;
      evt_q       <= evt_d;
    end
  end

  // read port
  always_comb begin
    unique case (sfr_addr_i)
      A_MODE:  sfr_rdata_o = {idle_gate_q, wdog_q, 3'b000, src_q, ien_q};
      A_CTRL:  sfr_rdata_o = {ovf_q, run_q, {(6-NUM_MOD){1'b0}}, evt_q};
      A_CLO:   sfr_rdata_o = count_o[7:0];
      default: sfr_rdata_o = count_o[CNT_W-1:8];
    endcase
  end

  assign irq_o     = (ovf_q & ien_q) | (|evt_q);
  assign wdog_en_o = wdog_q;

  // checks
  assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    wrap |=> ovf_q);
  assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(ovf_q) |-> $past(wr_ctrl && !sfr_wdata_i[C_OVF]));
  assert_idle_gate_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (idle_i && idle_gate_q && !wr_lo && !wr_hi) |=> $stable(count_o));
  generate
    for (genvar i = 0; i < NUM_MOD; i++) begin : g_evt_chk
      assert_evt_set_R9: assert property (@(posedge clk) disable iff (!rst_sn)
        mod_evt_i[i] |=> evt_q[i]);
      assert_evt_clear_R9: assert property (@(posedge clk) disable iff (!rst_sn)
        $fell(evt_q[i]) |-> $past(wr_ctrl && !sfr_wdata_i[i]));
      assert_evt_irq_R10: assert property (@(posedge clk) disable iff (!rst_sn)
        mod_evt_i[i] |=> irq_o);
    end
  endgenerate
endmodule

// File: tb/pca_timebase_bench.sv
module pca_timebase_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idle = 1'b0, t0 = 1'b0, pin = 1'b0, wr = 1'b0;
  logic [4:0] evt = '0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [15:0] count;
  logic       irq, wdog;

  always #10 clk = ~clk;

  pca_timebase u_pca_timebase (
    .clk(clk), .rst_n(rst_n), .idle_i(idle), .t0_ovf_i(t0), .ext_clk_i(pin),
    .mod_evt_i(evt), .sfr_wr_i(wr), .sfr_addr_i(addr), .sfr_wdata_i(wdata),
    .sfr_rdata_o(rdata), .count_o(count), .irq_o(irq), .wdog_en_o(wdog));

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit done = 0;

  // ---------------- reference model ----------------
  int m_cnt, m_phase, m_rel;
  bit m_idleg, m_wdog, m_ien, m_ovf, m_run;
  int m_src;
  bit [4:0] m_evt;
  bit pin_hist[$];
  bit m_live;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_phase = 0; m_rel = 0; m_live = 0;
      m_idleg = 0; m_wdog = 0; m_ien = 0; m_ovf = 0; m_run = 0; m_src = 0; m_evt = 0;
      pin_hist = '{0, 0, 0};
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit tick, rise, wrapped;
      m_live = 1;
      rise = pin_hist[1] && !pin_hist[2];
      case (m_src)
        0: tick = (m_phase == 11);
        1: tick = (m_phase % 4 == 3);
        2: tick = t0;
        default: tick = rise;
      endcase
      wrapped = 0;
      if (wr && addr == 2) m_cnt = (m_cnt / 256) * 256 + wdata;
      else if (wr && addr == 3) m_cnt = wdata * 256 + m_cnt % 256;
      else if (m_run && !(idle && m_idleg) && tick) begin
        wrapped = (m_cnt == 65535);
        m_cnt = (m_cnt + 1) % 65536;
      end
      if (wr && addr == 0) begin
        m_idleg = wdata[7]; m_wdog = wdata[6]; m_src = wdata[2:1]; m_ien = wdata[0];
      end
      if (wr && addr == 1) begin
        m_ovf = wdata[7]; m_run = wdata[6]; m_evt = wdata[4:0];
      end
      if (wrapped) m_ovf = 1;
      m_evt = m_evt | evt;
      m_phase = (m_phase + 1) % 12;
      pin_hist.push_front(pin);
      void'(pin_hist.pop_back());
    end
  end

  function automatic int exp_rd(input int a);
    case (a)
      0: return {m_idleg, m_wdog, 3'b000, m_src[1:0], m_ien};
      1: return {m_ovf, m_run, 1'b0, m_evt};
      2: return m_cnt % 256;
      default: return m_cnt / 256;
    endcase
  endfunction

  // per-cycle comparison, a quarter period after the rising edge
  always @(posedge clk) begin
    #5;
    if (m_live && !done) begin
      int e_irq;
      e_irq = (m_ovf && m_ien) || (m_evt != 0);
      total++;
      if (count !== 16'(m_cnt) || irq !== e_irq[0] || wdog !== m_wdog ||
          rdata !== 8'(exp_rd(addr))) begin
        bad++;
        $display("FAIL %s cycle: count=%h irq=%b wdog=%b rd=%h expected count=%h irq=%0d wdog=%b rd=%h",
                 cur_req, count, irq, wdog, rdata, m_cnt[15:0], e_irq, m_wdog, exp_rd(addr));
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic sfr_read(input logic [1:0] a, output int v);
    @(negedge clk); addr = a;
    @(posedge clk); #5; v = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    int v, c0;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(4);

    cur_req = "R1";
    chk("R1 count", count, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wdog", wdog, 0);
    for (int a = 0; a < 4; a++) begin
      sfr_read(2'(a), v);
      chk("R1 readback", v, 0);
    end

    cur_req = "R2";
    sfr_write(1, 8'h40);
    @(negedge clk); c0 = count;
    wait_cyc(120);
    chk("R2 div12 rate", count - c0, 10);

    cur_req = "R3";
    sfr_write(0, 8'h02);
    @(negedge clk); c0 = count;
    wait_cyc(100);
    chk("R3 div4 rate", count - c0, 25);

    cur_req = "R4";
    sfr_write(0, 8'h04);
    @(negedge clk); c0 = count;
    for (int i = 0; i < 40; i++) begin
      t0 = (i % 2 == 0) || (i % 7 == 3);
      @(negedge clk);
    end
    t0 = 0;
    @(negedge clk);
    chk("R4 t0 pulses", count - c0, 23);

    cur_req = "R5";
    sfr_write(0, 8'h06);
    @(negedge clk); c0 = count;
    for (int i = 0; i < 80; i++) begin
      pin = ((i / 4) % 2 == 1);
      @(negedge clk);
    end
    pin = 0;
    wait_cyc(4);
    chk("R5 ext edges", count - c0, 10);

    cur_req = "R6";
    sfr_write(0, 8'h02);
    sfr_write(1, 8'h00);
    @(negedge clk); c0 = count;
    wait_cyc(50);
    chk("R6 stopped", count - c0, 0);
    sfr_write(1, 8'h40);

    cur_req = "R7";
    sfr_write(0, 8'h82);
    idle = 1;
    @(negedge clk); c0 = count;
    wait_cyc(40);
    chk("R7 gated in idle", count - c0, 0);
    idle = 0;
    @(negedge clk); c0 = count;
    wait_cyc(40);
    chk("R7 runs out of idle", count - c0, 10);
    sfr_write(0, 8'h02);
    idle = 1;
    @(negedge clk); c0 = count;
    wait_cyc(40);
    chk("R7 idle ignored", count - c0, 10);
    idle = 0;

    cur_req = "R8";
    sfr_write(1, 8'h00);
    sfr_write(3, 8'hFF);
    sfr_write(2, 8'hF0);
    chk("R11 byte load", count, 16'hFFF0);
    sfr_write(0, 8'h03);
    sfr_write(1, 8'h40);
    wait_cyc(80);
    sfr_read(1, v);
    chk("R8 wrap sets flag", v[7], 1);
    chk("R10 overflow irq", irq, 1);
    sfr_write(0, 8'h02);
    @(negedge clk);
    chk("R10 overflow irq masked", irq, 0);
    sfr_write(1, 8'h40);
    sfr_read(1, v);
    chk("R8 software clear", v[7], 0);
    sfr_write(1, 8'hC0);
    sfr_read(1, v);
    chk("R8 software set", v[7], 1);
    sfr_write(1, 8'h00);
    sfr_write(0, 8'h04);
    sfr_write(3, 8'hFF);
    sfr_write(2, 8'hFF);
    sfr_write(1, 8'h40);
    @(negedge clk); wr = 1; addr = 1; wdata = 8'h40; t0 = 1;
    @(negedge clk); wr = 0; t0 = 0;
    sfr_read(1, v);
    chk("R8 hw set beats clear", v[7], 1);
    chk("R8 wrapped to zero", count, 0);

    cur_req = "R9";
    sfr_write(1, 8'h00);
    @(negedge clk); evt = 5'b00100;
    @(negedge clk); evt = 0;
    sfr_read(1, v);
    chk("R9 strobe sets flag", v, 8'h04);
    chk("R10 event irq", irq, 1);
    @(negedge clk); wr = 1; addr = 1; wdata = 8'h00; evt = 5'b00001;
    @(negedge clk); wr = 0; evt = 0;
    sfr_read(1, v);
    chk("R9 clear vs strobe", v, 8'h01);
    sfr_write(1, 8'h00);
    @(negedge clk);
    chk("R10 irq low", irq, 0);

    cur_req = "R11";
    sfr_write(0, 8'hFF);
    sfr_read(0, v);
    chk("R11 mode reserved", v, 8'hC7);
    chk("R12 wdog on", wdog, 1);
    sfr_write(1, 8'hFF);
    sfr_read(1, v);
    chk("R11 control reserved", v, 8'hDF);
    sfr_write(1, 8'h00);
    sfr_write(0, 8'h04);
    sfr_write(1, 8'h40);
    sfr_write(3, 8'h12);
    @(negedge clk); wr = 1; addr = 2; wdata = 8'h34; t0 = 1;
    @(negedge clk); wr = 0; t0 = 0;
    chk("R11 write beats increment", count, 16'h1234);

    cur_req = "R12";
    sfr_write(0, 8'h40);
    @(negedge clk);
    chk("R12 wdog set", wdog, 1);
    sfr_write(0, 8'h00);
    @(negedge clk);
    chk("R12 wdog clear", wdog, 0);

    wait_cyc(3);
    finish_run();
  end
endmodule